// File: doc/BRIEF.md
# Core Clock Source Controller

This block holds a 16-bit control register and uses it to drive the doubled core clock. The core clock can come from the chip input clock, from a PLL output, or from a slow clock. The slow clock is itself one of three divided copies of the input clock (by 4, 32 or 128) or the internal ring oscillator. Every change of source goes through a glitch-free switch. The old clock is released on its own falling edge after a two-flop synchronizer, and the new clock starts only after that.

The register also sets three enable outputs, for the PLL, the crystal oscillator and the ring oscillator. These follow two override rules. The PLL enable is forced on while the PLL is selected. A crystal-off request waits until the ring oscillator is actually clocking the core. A debug output can show one of several internal clocks or a constant level. The register is written and read in the input clock domain.

Top module: `clk_src_ctrl`

## Requirements
- R1: Control bits 15..13 are read-only zeros, and writes to them are ignored. Bits 12..0 read back as last written. Bit 12 has no effect on the clocks and appears on `volt_sel_o`.
- R2: Reset clears the whole register to zero. After reset, `pll_en_o` is 0 and the core clock runs from the input clock.
- R3: Core select field bits 5..4 pick the core clock source:
  - 00 selects the input clock.
  - 01 or 11 selects the PLL clock.
  - 10 selects the slow clock.
- R4: Slow clock field bits 7..6 pick the slow clock source:
  - 00 selects the input clock divided by 4.
  - 01 selects the input clock divided by 32.
  - 10 selects the input clock divided by 128.
  - 11 selects the ring oscillator input.
- R5: When bit 3 is 1, the core clock stops and holds low. When bit 3 is 0, the core clock runs from the selected source.
- R6: `pll_en_o` is the OR of bit 0 and bit 4, so selecting the PLL forces it on.
- R7: `ring_en_o` is the inverse of bit 2.
- R8: `xtal_en_o` is 0 only when bit 1 is 1 and the ring oscillator is actively clocking the core. While the switch to the ring is still in progress, `xtal_en_o` stays 1.
- R9: Debug field bits 11..8 drive `dbg_clk_o` as follows:
  - Codes 0, 6 and 8..15 give constant 0.
  - Code 1 gives the input clock.
  - Code 2 gives the slow clock.
  - Code 3 gives the wait-stated clock.
  - Code 4 gives the free-running clock.
  - Code 5 gives the core clock.
  - Code 7 gives constant 1.
- R10: During any source change or stop, the core clock never shows a high or low pulse shorter than the shortest half period of the sources involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Chip input clock; also clocks the register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pll_clk_i | input | 1 | PLL output clock |
| ring_clk_i | input | 1 | Ring oscillator clock |
| wait_clk_i | input | 1 | Wait-stated clock, used only for debug |
| free_clk_i | input | 1 | Free-running clock, used only for debug |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| core_clk_o | output | 1 | Doubled core clock |
| dbg_clk_o | output | 1 | Debug clock or level output |
| pll_en_o | output | 1 | PLL enable |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| ring_en_o | output | 1 | Ring oscillator enable |
| volt_sel_o | output | 1 | Stored voltage select flag |

## Verification
The assertions assume three things about the inputs:
- The write strobe and data are synchronous to the input clock.
- Every source clock keeps toggling, including the ring clock while its enable is low.
- The debug and enable outputs may be judged at input-clock edges.

The stimulus respects these assumptions. It drives writes on the falling edge of the input clock and keeps all five source clocks free-running at fixed, distinct periods. After each write, it waits well past the slowest switch-over before measuring the output periods. A pulse-width monitor covers every switch, except around deliberate resets.

// File: rtl/clk_src_pkg.sv
`timescale 1ns/1ps
package clk_src_pkg;
  localparam int unsigned CTRL_W     = 16;
  localparam int unsigned VOLT_B     = 12;
  localparam int unsigned DBG_LSB    = 8;
  localparam int unsigned DBG_W      = 4;
  localparam int unsigned LOW_LSB    = 6;
  localparam int unsigned CORE_LSB   = 4;
  localparam int unsigned STOP_B     = 3;
  localparam int unsigned RING_DIS_B = 2;
  localparam int unsigned XTAL_DIS_B = 1;
  localparam int unsigned PLL_EN_B   = 0;
  localparam logic [CTRL_W-1:0] RW_MASK = 16'h1FFF;

  typedef enum logic [1:0] {
    CORE_IN  = 2'd0,
    CORE_PLL = 2'd1,
    CORE_LOW = 2'd2
  } core_src_e;

  typedef enum logic [1:0] {
    LOW_D4   = 2'd0,
    LOW_D32  = 2'd1,
    LOW_D128 = 2'd2,
    LOW_RING = 2'd3
  } low_src_e;

  typedef enum logic [DBG_W-1:0] {
    DBG_ZERO = 4'd0,
    DBG_IN   = 4'd1,
    DBG_LOW  = 4'd2,
    DBG_WAIT = 4'd3,
    DBG_FREE = 4'd4,
    DBG_CORE = 4'd5,
    DBG_Z6   = 4'd6,
    DBG_ONE  = 4'd7
  } dbg_sel_e;

  // field bit0 wins: x1 -> PLL
  function automatic core_src_e core_decode(logic [1:0] f);
    if (f[0])      return CORE_PLL;
    else if (f[1]) return CORE_LOW;
    else           return CORE_IN;
  endfunction
endpackage

// File: rtl/clk_div.sv
`timescale 1ns/1ps
module clk_div #(
  parameter int unsigned LOG_A = 2,
  parameter int unsigned LOG_B = 5,
  parameter int unsigned LOG_C = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic div_a_o,
  output logic div_b_o,
  output logic div_c_o
);
  localparam int unsigned CNT_W = LOG_C;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign div_a_o = cnt_q[LOG_A-1];
  assign div_b_o = cnt_q[LOG_B-1];
  assign div_c_o = cnt_q[LOG_C-1];
endmodule

// File: rtl/clk_gf_mux.sv
`timescale 1ns/1ps
module clk_gf_mux #(
  parameter int unsigned N     = 3,
  parameter int unsigned SYNC  = 2,
  parameter int unsigned WATCH = 0,
  localparam int unsigned SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     src_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             hold_i,
  output logic             clk_o,
  output logic             watch_o
);
  logic [N-1:0] en_v;
  logic [N-1:0] gated;

  for (genvar g = 0; g < N; g++) begin : g_src
    logic            req;
    logic            en_q;
    logic [SYNC-1:0] sync_q;

    // start only once every other leg is released
    assign req = !hold_i && (sel_i == SEL_W'(g)) && !(|(en_v & ~(N'(1) << g)));

    always_ff @(posedge src_i[g] or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[SYNC-2:0], req};
    end

    // enable changes only while this source is low
    always_ff @(negedge src_i[g] or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b0;
      else         en_q <= sync_q[SYNC-1];
    end

    assign en_v[g]  = en_q;
    assign gated[g] = src_i[g] & en_q;
  end

  assign clk_o   = |gated;
  assign watch_o = en_v[WATCH];
endmodule

// File: rtl/clk_dbg_mux.sv
`timescale 1ns/1ps
module clk_dbg_mux
  import clk_src_pkg::*;
(
  input  logic [DBG_W-1:0] sel_i,
  input  logic             in_clk_i,
  input  logic             low_clk_i,
  input  logic             wait_clk_i,
  input  logic             free_clk_i,
  input  logic             core_clk_i,
  output logic             dbg_o
);
  always_comb begin
    case (sel_i)
      DBG_IN:   dbg_o = in_clk_i;
      DBG_LOW:  dbg_o = low_clk_i;
      DBG_WAIT: dbg_o = wait_clk_i;
      DBG_FREE: dbg_o = free_clk_i;
      DBG_CORE: dbg_o = core_clk_i;
      DBG_ONE:  dbg_o = 1'b1;
      default:  dbg_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/clk_src_ctrl.sv
`timescale 1ns/1ps
module clk_src_ctrl
  import clk_src_pkg::*;
#(
  parameter int unsigned SYNC   = 2,
  parameter int unsigned LOG_D0 = 2,
  parameter int unsigned LOG_D1 = 5,
  parameter int unsigned LOG_D2 = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pll_clk_i,
  input  logic              ring_clk_i,
  input  logic              wait_clk_i,
  input  logic              free_clk_i,
  input  logic              reg_we_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  output logic [CTRL_W-1:0] reg_rdata_o,
  output logic              core_clk_o,
  output logic              dbg_clk_o,
  output logic              pll_en_o,
  output logic              xtal_en_o,
  output logic              ring_en_o,
  output logic              volt_sel_o
);
  localparam int unsigned N_CORE = 3;
  localparam int unsigned N_LOW  = 4;

  logic [CTRL_W-1:0] ctrl_q;
  core_src_e         core_sel;
  logic              d4_clk, d32_clk, d128_clk;
  logic              low_clk;
  logic              core_low_on, low_ring_on;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (reg_we_i) ctrl_q <= reg_wdata_i & RW_MASK;
  end

  assign reg_rdata_o = ctrl_q;
  assign volt_sel_o  = ctrl_q[VOLT_B];
  assign core_sel    = core_decode(ctrl_q[CORE_LSB +: 2]);

  clk_div #(
    .LOG_A(LOG_D0),
    .LOG_B(LOG_D1),
    .LOG_C(LOG_D2)
  ) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_a_o(d4_clk),
    .div_b_o(d32_clk),
    .div_c_o(d128_clk)
  );

  clk_gf_mux #(
    .N    (N_LOW),
    .SYNC (SYNC),
    .WATCH(int'(LOW_RING))
  ) u_low_mux (
    .src_i  ({ring_clk_i, d128_clk, d32_clk, d4_clk}),
    .rst_ni (rst_ni),
    .sel_i  (ctrl_q[LOW_LSB +: 2]),
    .hold_i (1'b0),
    .clk_o  (low_clk),
    .watch_o(low_ring_on)
  );

  clk_gf_mux #(
    .N    (N_CORE),
    .SYNC (SYNC),
    .WATCH(int'(CORE_LOW))
  ) u_core_mux (
    .src_i  ({low_clk, pll_clk_i, clk_i}),
    .rst_ni (rst_ni),
    .sel_i  (core_sel),
    .hold_i (ctrl_q[STOP_B]),
    .clk_o  (core_clk_o),
    .watch_o(core_low_on)
  );

  assign pll_en_o  = ctrl_q[PLL_EN_B] | ctrl_q[CORE_LSB];
  assign ring_en_o = ~ctrl_q[RING_DIS_B];
  // crystal may only drop once the ring really drives the core
  assign xtal_en_o = ~(ctrl_q[XTAL_DIS_B] & core_low_on & low_ring_on);

  clk_dbg_mux u_dbg (
    .sel_i     (ctrl_q[DBG_LSB +: DBG_W]),
    .in_clk_i  (clk_i),
    .low_clk_i (low_clk),
    .wait_clk_i(wait_clk_i),
    .free_clk_i(free_clk_i),
    .core_clk_i(core_clk_o),
    .dbg_o     (dbg_clk_o)
  );
endmodule

// File: rtl/clk_src_ctrl_chk.sv
`timescale 1ns/1ps
module clk_src_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [15:0] reg_wdata_i,
  input logic [15:0] reg_rdata_o,
  input logic        pll_en_o,
  input logic        ring_en_o,
  input logic        xtal_en_o,
  input logic        dbg_clk_o
);
  // R1
  wr_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> reg_rdata_o == {3'b000, $past(reg_wdata_i[12:0])});

  // R6
  pll_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[4] |-> pll_en_o);

  // R7
  ring_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_en_o != reg_rdata_o[2]);

  // R8
  xtal_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[1] |-> xtal_en_o);

  // R9
  dbg_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[11:8] == 4'd7) |-> dbg_clk_o);

  // R9
  dbg_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[11:8] == 4'd0 || reg_rdata_o[11:8] == 4'd6 || reg_rdata_o[11])
      |-> !dbg_clk_o);
endmodule

bind clk_src_ctrl clk_src_ctrl_chk chk_i (.*);

// File: tb/clk_src_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_src_ctrl_tb_top;
  logic        clk_i = 1'b0, pll_clk = 1'b0, ring_clk = 1'b0, wait_clk = 1'b0, free_clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        core_clk, dbg_clk, pll_en, xtal_en, ring_en, volt_sel;

  int n_chk = 0;
  int n_fail = 0;

  always #4   clk_i    = ~clk_i;   // 125 MHz
  always #3   pll_clk  = ~pll_clk;
  always #11  ring_clk = ~ring_clk;
  always #8   wait_clk = ~wait_clk;
  always #5   free_clk = ~free_clk;

  clk_src_ctrl dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pll_clk_i  (pll_clk),
    .ring_clk_i (ring_clk),
    .wait_clk_i (wait_clk),
    .free_clk_i (free_clk),
    .reg_we_i   (we),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .core_clk_o (core_clk),
    .dbg_clk_o  (dbg_clk),
    .pll_en_o   (pll_en),
    .xtal_en_o  (xtal_en),
    .ring_en_o  (ring_en),
    .volt_sel_o (volt_sel)
  );

  // edge trackers
  real core_t0 = 0.0, core_t1 = 0.0, dbg_t0 = 0.0, dbg_t1 = 0.0, lvl_t = 0.0;
  int  core_n = 0, dbg_n = 0, glitch_n = 0;
  bit  mon_en = 1'b0;

  always @(posedge core_clk) begin core_t0 = core_t1; core_t1 = $realtime; core_n++; end
  always @(posedge dbg_clk)  begin dbg_t0 = dbg_t1;   dbg_t1 = $realtime;  dbg_n++;  end
  always @(core_clk) begin
    if (mon_en && lvl_t > 0.0 && ($realtime - lvl_t) < 2.9) glitch_n++;
    lvl_t = $realtime;
  end

  task automatic chk(input bit ok, input string tag, input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0.2f expected %0.2f at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk_i);
    we = 1'b1; wdata = d;
    @(negedge clk_i);
    we = 1'b0;
  endtask

  task automatic meas_core(output real per);
    int n0 = core_n;
    per = 0.0;
    for (int k = 0; k < 3000; k++) begin
      #1;
      if (core_n >= n0 + 2) break;
    end
    if (core_n >= n0 + 2) per = core_t1 - core_t0;
  endtask

  task automatic meas_dbg(output real per);
    int n0 = dbg_n;
    per = 0.0;
    for (int k = 0; k < 3000; k++) begin
      #1;
      if (dbg_n >= n0 + 2) break;
    end
    if (dbg_n >= n0 + 2) per = dbg_t1 - dbg_t0;
  endtask

  function automatic bit near(real a, real b);
    return (a - b < 0.5) && (b - a < 0.5);
  endfunction

  typedef struct packed {
    logic [15:0] wdata;
    logic [15:0] core_per;  // 0: stopped
    logic [15:0] dbg_per;   // 0: constant level
    logic        dbg_lvl;
    logic        pll;
    logic        ring;
    logic        xtal;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{16'h0000,   16'd8,    16'd0, 1'b0, 1'b0, 1'b1, 1'b1},  // R3 R9 in, code0
    '{16'h0111,   16'd6,    16'd8, 1'b0, 1'b1, 1'b1, 1'b1},  // R3 R9 pll, code1
    '{16'h0010,   16'd6,    16'd0, 1'b0, 1'b1, 1'b1, 1'b1},  // R6 forced
    '{16'h0220,  16'd32,   16'd32, 1'b0, 1'b0, 1'b1, 1'b1},  // R4 /4
    '{16'h0260, 16'd256,  16'd256, 1'b0, 1'b0, 1'b1, 1'b1},  // R4 /32
    '{16'h02A0, 16'd1024, 16'd1024,1'b0, 1'b0, 1'b1, 1'b1},  // R4 /128
    '{16'h02E0,  16'd22,   16'd22, 1'b0, 1'b0, 1'b1, 1'b1},  // R4 ring
    '{16'h02E2,  16'd22,   16'd22, 1'b0, 1'b0, 1'b1, 1'b0},  // R8 crystal off
    '{16'h0322,  16'd32,   16'd16, 1'b0, 1'b0, 1'b1, 1'b1},  // R8 held, R9 wait
    '{16'h0431,   16'd6,   16'd10, 1'b0, 1'b1, 1'b1, 1'b1},  // R3 code 11, R9 free
    '{16'h0504,   16'd8,    16'd8, 1'b0, 1'b0, 1'b0, 1'b1},  // R7 R9 core
    '{16'h0708,   16'd0,    16'd0, 1'b1, 1'b0, 1'b1, 1'b1},  // R5 stop, R9 one
    '{16'h0600,   16'd8,    16'd0, 1'b0, 1'b0, 1'b1, 1'b1},  // R9 code6
    '{16'h0F00,   16'd8,    16'd0, 1'b0, 1'b0, 1'b1, 1'b1},  // R9 code15
    '{16'hF000,   16'd8,    16'd0, 1'b0, 1'b0, 1'b1, 1'b1}   // R1 reserved
  };

  initial begin : watchdog
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    real per;
    int  n0;
    bit  lvl_ok;

    // R2 reset state
    #21;
    chk(rdata == 16'h0000, "R2 rdata", real'(rdata), 0.0);
    chk(pll_en == 1'b0, "R2 pll_en", real'(pll_en), 0.0);
    chk(core_clk == 1'b0, "R2 core idle", real'(core_clk), 0.0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    mon_en = 1'b1;
    #2002;
    meas_core(per);
    chk(near(per, 8.0), "R2 core from input", per, 8.0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].wdata);
      #4002;
      chk(rdata == (VEC[i].wdata & 16'h1FFF), "R1 readback", real'(rdata),
          real'(VEC[i].wdata & 16'h1FFF));
      chk(volt_sel == VEC[i].wdata[12], "R1 volt_sel", real'(volt_sel), real'(VEC[i].wdata[12]));
      chk(pll_en == VEC[i].pll, "R6 pll_en", real'(pll_en), real'(VEC[i].pll));
      chk(ring_en == VEC[i].ring, "R7 ring_en", real'(ring_en), real'(VEC[i].ring));
      chk(xtal_en == VEC[i].xtal, "R8 xtal_en", real'(xtal_en), real'(VEC[i].xtal));
      if (VEC[i].core_per == 0) begin
        n0 = core_n;
        #2000;
        chk(core_n == n0 && core_clk == 1'b0, "R5 core stopped", real'(core_n - n0), 0.0);
      end else begin
        meas_core(per);
        chk(near(per, real'(VEC[i].core_per)), "R3 R4 core period", per, real'(VEC[i].core_per));
      end
      if (VEC[i].dbg_per == 0) begin
        lvl_ok = 1'b1;
        for (int k = 0; k < 100; k++) begin
          #1;
          if (dbg_clk != VEC[i].dbg_lvl) lvl_ok = 1'b0;
        end
        chk(lvl_ok, "R9 dbg level", real'(dbg_clk), real'(VEC[i].dbg_lvl));
      end else begin
        meas_dbg(per);
        chk(near(per, real'(VEC[i].dbg_per)), "R9 dbg period", per, real'(VEC[i].dbg_per));
      end
    end

    // R8 crystal stays on while the switch to the ring is in flight
    wr(16'h0000);
    #4002;
    wr(16'h02E2);
    #12;
    chk(xtal_en == 1'b1, "R8 xtal during switch", real'(xtal_en), 1.0);
    #4002;
    chk(xtal_en == 1'b0, "R8 xtal after switch", real'(xtal_en), 0.0);
    meas_core(per);
    chk(near(per, 22.0), "R4 ring core period", per, 22.0);

    // R2 reset in mid-run
    wr(16'h0431);
    #2002;
    mon_en = 1'b0;
    rst_ni = 1'b0;
    #20;
    chk(rdata == 16'h0000, "R2 mid reset rdata", real'(rdata), 0.0);
    chk(pll_en == 1'b0, "R2 mid reset pll_en", real'(pll_en), 0.0);
    chk(core_clk == 1'b0, "R2 mid reset core", real'(core_clk), 0.0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #2002;
    lvl_t = 0.0;
    mon_en = 1'b1;
    meas_core(per);
    chk(near(per, 8.0), "R2 core after reset", per, 8.0);

    // R10 no runt pulses across every switch above
    chk(glitch_n == 0, "R10 runt pulses", real'(glitch_n), 0.0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule